// File: doc/BRIEF.md
# Sync Mode Selector with Auto-Detect

This block decides how a switching controller relates to a shared synchronization pin. A byte-wide configuration register, loaded at reset from a default input and rewritten over a simple write-strobe bus, picks one of four modes and the clock edge the controller locks to. The four modes are: no synchronization, drive the pin, follow the pin, and auto-detect. Writes whose low five bits are not the fixed filler code are refused, and a sticky status flag records the refusal.

In auto-detect mode the input-or-output choice is made once, when the enable input rises. The block uses the pin's digitized level at that moment and an edge rate measured over a fixed window of nominal switching periods. While it follows the pin, it watches for missing or lost edges and raises a sticky fault. It also reports which frequency regime the converter is in. That regime covers nominal internal clocking, tracking the pin, tracking clamped at the 70% lower limit, held off by a fault, and parked at the lower limit after a live change from follow to drive. When it drives the pin, it produces a square wave at the nominal period, or at the lower-limit period while parked.

Top module: `sync_mode_ctrl`

## Requirements
- R1: After reset, rd_data equals {cfg_default[7:5], 5'b10000}, and sync_fault and bad_wr_flag are 0.
- R2: A write with wr_data[4:0] == 5'b10000 replaces the register, and rd_data shows the new value on the cycle after the strobe.
- R3: A write with any other wr_data[4:0] leaves rd_data unchanged and sets bad_wr_flag. The flag stays set until a stat_clr pulse arrives in a cycle with no refused write.
- R4: Mode field rd_data[7:6] maps as follows. 00 gives eff_dir 00 (none), 01 gives eff_dir 01 (drive), 10 gives eff_dir 10 (follow), and 11 is auto-detect. sync_oe is high only while enable is high and eff_dir is 01, and sync_out is 0 whenever sync_oe is low.
- R5: In auto-detect mode, eff_dir becomes 00 while disabled. On the rising edge of enable it becomes 10 if the pin is high, or if the last completed window of PERIOD_CYC*WIN_PERIODS cycles held at least ceil(0.75*WIN_PERIODS) selected-polarity edges. Otherwise it becomes 01. The choice holds until enable falls.
- R6: Bit 5 selects the edge, with 1 for rising and 0 for falling. Only edges of that polarity are counted on the pin. When driving, the first sync_out value after sync_oe rises equals bit 5, so the period starts with the selected edge.
- R7: In follow mode while enabled, sync_fault is set if no selected edge has arrived within the last 2*ceil(PERIOD_CYC/0.7) cycles. This covers an enable before any edges and a loss of edges during operation.
- R8: sync_fault is sticky. It is cleared by a stat_clr pulse once edges are present, or on the cycle after enable is low.
- R9: freq_mode codes are: 0 off, 1 nominal, 2 tracking, 3 tracking at the lower limit, 4 held by fault, 5 parked low. In follow mode while enabled, the output is 4 if faulted. Otherwise it is 3 when the last edge interval is at least ceil(PERIOD_CYC/0.7) cycles, and 2 when it is shorter.
- R10: A change from follow to drive while enabled and at code 3 or 4 gives code 5. The driven period is then ceil(PERIOD_CYC/0.7) cycles until enable falls, whatever later writes do. A change from code 2 gives code 1 and a period of PERIOD_CYC.
- R11: freq_mode is 0 while enable is low. It is 1 while enabled in mode none or drive, when not parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_default | input | 8 | Register value loaded at reset (low five bits replaced by filler) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| stat_clr | input | 1 | Clear strobe for both sticky flags |
| bad_wr_flag | output | 1 | Sticky flag for a refused write |
| enable | input | 1 | Converter enable condition |
| sync_pin | input | 1 | Digitized synchronization pin level |
| sync_oe | output | 1 | Drive enable for the synchronization pin |
| sync_out | output | 1 | Driven synchronization waveform |
| eff_dir | output | 2 | Resolved direction: 00 none, 01 drive, 10 follow |
| freq_mode | output | 3 | Frequency regime code |
| sync_fault | output | 1 | Sticky missing or lost sync fault |

## Verification
The hardest state to reach is the parked-low regime. Reaching it needs the block enabled in follow mode with pin edges spaced just beyond the 70% limit, or faulted, and then a live register write to drive mode. The stimulus toggles the pin at a 30-cycle period (or stops it) and issues that write while enabled. It then checks that a later write back to follow mode does not leave the parked state. Auto-detect trials need the enable to rise only after a full measurement window of a steady pin rate and at a moment when the pin level is unambiguous. The bench therefore waits two windows and aligns the enable to the middle of a pin half-period.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_OUT  = 2'b01,
        MODE_IN   = 2'b10,
        MODE_AUTO = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_OUT  = 2'b01,
        DIR_IN   = 2'b10
    } dir_e;

    typedef enum logic [2:0] {
        FRQ_OFF       = 3'd0,
        FRQ_NOM       = 3'd1,
        FRQ_TRACK     = 3'd2,
        FRQ_TRACK_LOW = 3'd3,
        FRQ_HELD      = 3'd4,
        FRQ_PARK_LOW  = 3'd5
    } freq_e;

    typedef struct packed {
        mode_e      mode;
        logic       edge_rise;
        logic [4:0] fill;
    } cfg_t;

    typedef struct packed {
        logic lvl;
        logic present;
        logic fast;
        logic at_limit;
    } pin_meas_t;

    localparam logic [4:0] FILL_CODE = 5'b10000;

    function automatic logic cfg_ok(input logic [7:0] b);
        return b[4:0] == FILL_CODE;
    endfunction

    function automatic cfg_t cfg_from_default(input logic [7:0] b);
        cfg_t c;
        c.mode      = mode_e'(b[7:6]);
        c.edge_rise = b[5];
        c.fill      = FILL_CODE;
        return c;
    endfunction

    function automatic int lim_cycles(input int period);
        return (period * 10 + 6) / 7;
    endfunction

endpackage

// File: rtl/sync_cfg_reg.sv
module sync_cfg_reg
    import sync_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg_default,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       stat_clr,
    output cfg_t       cfg,
    output logic       bad_wr
);
    logic wr_good;
    logic wr_bad;

    always_comb begin
        wr_good = wr_en && cfg_ok(wr_data);
        wr_bad  = wr_en && !cfg_ok(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= cfg_from_default(cfg_default);
            bad_wr <= 1'b0;
        end else begin
            if (wr_good) begin
                cfg <= cfg_t'(wr_data);
            end
            if (wr_bad) begin
                bad_wr <= 1'b1;
            end else if (stat_clr) begin
                bad_wr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sync_edge_meter.sv
module sync_edge_meter
    import sync_mode_pkg::*;
#(
    parameter int PERIOD_CYC  = 20,
    parameter int WIN_PERIODS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_pin,
    input  logic      edge_rise,
    output pin_meas_t meas
);
    localparam int WIN_CYC  = PERIOD_CYC * WIN_PERIODS;
    localparam int THR      = (WIN_PERIODS * 3 + 3) / 4;
    localparam int LIM_CYC  = lim_cycles(PERIOD_CYC);
    localparam int LOSS_CYC = 2 * LIM_CYC;
    localparam int GAP_W    = $clog2(LOSS_CYC + 1);
    localparam int WIN_W    = $clog2(WIN_CYC);
    localparam int ECNT_W   = $clog2(WIN_CYC + 1);

    logic [SYNC_STAGES:0] sh;
    logic                 lvl;
    logic                 prv;
    logic                 q_edge;

    always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= sync_pin;
    end

    genvar g;
    generate
        for (g = 1; g <= SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) sh[g] <= 1'b0;
                else     sh[g] <= sh[g-1];
            end
        end
    endgenerate

    always_comb begin
        lvl    = sh[SYNC_STAGES-1];
        prv    = sh[SYNC_STAGES];
        q_edge = edge_rise ? (lvl & ~prv) : (~lvl & prv);
    end

    logic [GAP_W-1:0]  gap;
    logic [GAP_W-1:0]  last_int;
    logic [WIN_W-1:0]  wcnt;
    logic [ECNT_W-1:0] ecnt;
    logic              fast_q;
    logic              gap_full;

    assign gap_full = (gap == GAP_W'(LOSS_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= GAP_W'(LOSS_CYC);
            last_int <= '0;
        end else if (q_edge) begin
            last_int <= gap_full ? GAP_W'(LOSS_CYC) : gap + GAP_W'(1);
            gap      <= '0;
        end else if (!gap_full) begin
            gap <= gap + GAP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt   <= '0;
            ecnt   <= '0;
            fast_q <= 1'b0;
        end else if (wcnt == WIN_W'(WIN_CYC - 1)) begin
            wcnt   <= '0;
            ecnt   <= '0;
            fast_q <= (ecnt + ECNT_W'(q_edge)) >= ECNT_W'(THR);
        end else begin
            wcnt <= wcnt + WIN_W'(1);
            ecnt <= ecnt + ECNT_W'(q_edge);
        end
    end

    always_comb begin
        meas.lvl      = lvl;
        meas.present  = !gap_full;
        meas.fast     = fast_q;
        meas.at_limit = last_int >= GAP_W'(LIM_CYC);
    end
endmodule

// File: rtl/sync_dir_resolver.sv
module sync_dir_resolver
    import sync_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      stat_clr,
    input  mode_e     mode,
    input  pin_meas_t meas,
    output dir_e      dir,
    output freq_e     freq,
    output logic      fault,
    output logic      park
);
    logic  en_d;
    logic  en_rise;
    dir_e  auto_pick;
    dir_e  auto_q;
    dir_e  dir_q;
    freq_e freq_q;
    logic  fault_q;
    logic  park_q;

    always_comb begin
        en_rise   = enable && !en_d;
        auto_pick = (meas.lvl || meas.fast) ? DIR_IN : DIR_OUT;
        case (mode)
            MODE_OFF: dir = DIR_NONE;
            MODE_OUT: dir = DIR_OUT;
            MODE_IN:  dir = DIR_IN;
            default:  dir = !enable ? DIR_NONE : (en_rise ? auto_pick : auto_q);
        endcase
    end

    always_comb begin
        if (!enable)           freq = FRQ_OFF;
        else if (park_q)       freq = FRQ_PARK_LOW;
        else if (dir == DIR_IN) begin
            if (fault_q)            freq = FRQ_HELD;
            else if (meas.at_limit) freq = FRQ_TRACK_LOW;
            else                    freq = FRQ_TRACK;
        end else                freq = FRQ_NOM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d    <= 1'b0;
            auto_q  <= DIR_NONE;
            dir_q   <= DIR_NONE;
            freq_q  <= FRQ_OFF;
            fault_q <= 1'b0;
            park_q  <= 1'b0;
        end else begin
            en_d   <= enable;
            dir_q  <= dir;
            freq_q <= freq;
            if (en_rise) auto_q <= auto_pick;

            if (!enable)                           fault_q <= 1'b0;
            else if (dir == DIR_IN && !meas.present) fault_q <= 1'b1;
            else if (stat_clr)                     fault_q <= 1'b0;

            if (!enable) begin
                park_q <= 1'b0;
            end else if (dir_q == DIR_IN && dir == DIR_OUT &&
                         (freq_q == FRQ_TRACK_LOW || freq_q == FRQ_HELD)) begin
                park_q <= 1'b1;
            end
        end
    end

    assign fault = fault_q;
    assign park  = park_q;
endmodule

// File: rtl/sync_osc.sv
module sync_osc
    import sync_mode_pkg::*;
#(
    parameter int PERIOD_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic park,
    input  logic edge_rise,
    output logic sync_out
);
    localparam int LIM_CYC = lim_cycles(PERIOD_CYC);
    localparam int PH_W    = $clog2(LIM_CYC + 1);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] per_m1;
    logic [PH_W-1:0] half;
    logic            raw;

    always_comb begin
        per_m1   = park ? PH_W'(LIM_CYC - 1) : PH_W'(PERIOD_CYC - 1);
        half     = park ? PH_W'(LIM_CYC / 2) : PH_W'(PERIOD_CYC / 2);
        raw      = phase < half;
        sync_out = run && (edge_rise ? raw : !raw);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)        phase <= '0;
        else if (phase >= per_m1) phase <= '0;
        else                    phase <= phase + PH_W'(1);
    end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int PERIOD_CYC  = 20,
    parameter int WIN_PERIODS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg_default,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       stat_clr,
    output logic       bad_wr_flag,
    input  logic       enable,
    input  logic       sync_pin,
    output logic       sync_oe,
    output logic       sync_out,
    output logic [1:0] eff_dir,
    output logic [2:0] freq_mode,
    output logic       sync_fault
);
    cfg_t      cfg;
    pin_meas_t meas;
    dir_e      dir;
    freq_e     freq;
    logic      park;
    logic      run;

    sync_cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_default (cfg_default),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .stat_clr    (stat_clr),
        .cfg         (cfg),
        .bad_wr      (bad_wr_flag)
    );

    sync_edge_meter #(
        .PERIOD_CYC  (PERIOD_CYC),
        .WIN_PERIODS (WIN_PERIODS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .sync_pin  (sync_pin),
        .edge_rise (cfg.edge_rise),
        .meas      (meas)
    );

    sync_dir_resolver u_res (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .stat_clr (stat_clr),
        .mode     (cfg.mode),
        .meas     (meas),
        .dir      (dir),
        .freq     (freq),
        .fault    (sync_fault),
        .park     (park)
    );

    assign run = enable && (dir == DIR_OUT);

    sync_osc #(
        .PERIOD_CYC (PERIOD_CYC)
    ) u_osc (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .park      (park),
        .edge_rise (cfg.edge_rise),
        .sync_out  (sync_out)
    );

    assign rd_data   = cfg;
    assign sync_oe   = run;
    assign eff_dir   = dir;
    assign freq_mode = freq;
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg_default,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       stat_clr,
    input logic       bad_wr_flag,
    input logic       enable,
    input logic       sync_pin,
    input logic       sync_oe,
    input logic       sync_out,
    input logic [1:0] eff_dir,
    input logic [2:0] freq_mode,
    input logic       sync_fault
);
    AST_VALID_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4:0] == 5'b10000) |=> rd_data == $past(wr_data)); // R2
    AST_BAD_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4:0] != 5'b10000) |=> (rd_data == $past(rd_data) && bad_wr_flag)); // R3
    AST_OE_DRIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
        sync_oe |-> (eff_dir == 2'b01 && enable)); // R4
    AST_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        !sync_oe |-> !sync_out); // R4
    AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && rd_data[7:6] == 2'b11 && $past(rd_data[7:6]) == 2'b11)
        |-> $stable(eff_dir)); // R5
    AST_FAULT_IN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_fault) |-> $past(eff_dir) == 2'b10); // R7
    AST_FAULT_DROP: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !sync_fault); // R8
    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && $past(freq_mode) == 3'd5) |-> freq_mode == 3'd5); // R10
    AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (freq_mode == 3'd0 && !sync_oe)); // R11
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk chk_i (.*);

// File: tb/sync_mode_ctrl_tb_top.sv
module sync_mode_ctrl_tb_top;
    localparam int PER  = 20;
    localparam int WINP = 8;
    localparam int WINC = PER * WINP;
    localparam int THR  = (WINP * 3 + 3) / 4;
    localparam int LIM  = (PER * 10 + 6) / 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_default = 8'b1010_0111;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       stat_clr = 1'b0;
    logic       bad_wr_flag;
    logic       enable = 1'b0;
    logic       sync_pin = 1'b0;
    logic       sync_oe;
    logic       sync_out;
    logic [1:0] eff_dir;
    logic [2:0] freq_mode;
    logic       sync_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int pin_half = 0;
    logic pin_static = 1'b0;
    int tog_cnt = 0;

    always #5 clk = ~clk;

    sync_mode_ctrl #(.PERIOD_CYC(PER), .WIN_PERIODS(WINP)) dut_i (
        .clk(clk), .rst(rst), .cfg_default(cfg_default), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .stat_clr(stat_clr),
        .bad_wr_flag(bad_wr_flag), .enable(enable), .sync_pin(sync_pin),
        .sync_oe(sync_oe), .sync_out(sync_out), .eff_dir(eff_dir),
        .freq_mode(freq_mode), .sync_fault(sync_fault)
    );

    // pin generator: period 2*pin_half, or static level when pin_half == 0
    always @(negedge clk) begin
        if (pin_half == 0) begin
            sync_pin <= pin_static;
            tog_cnt  <= 0;
        end else if (tog_cnt + 1 >= pin_half) begin
            sync_pin <= ~sync_pin;
            tog_cnt  <= 0;
        end else begin
            tog_cnt <= tog_cnt + 1;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        step(1);
        wr_en = 1'b1;
        wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        stat_clr = 1'b1;
        step(1);
        stat_clr = 1'b0;
    endtask

    task automatic set_pin(input int per, input logic lvl);
        pin_half = per / 2;
        pin_static = lvl;
    endtask

    task automatic meas_per(output int p);
        int t0;
        int t;
        logic prev;
        p = -1;
        t0 = -1;
        t = 0;
        prev = sync_out;
        for (int i = 0; i < 200; i++) begin
            step(1);
            t++;
            if (!prev && sync_out) begin
                if (t0 < 0) t0 = t;
                else begin
                    p = t - t0;
                    break;
                end
            end
            prev = sync_out;
        end
    endtask

    function automatic bit exp_fast(input int per);
        return per != 0 && (WINC / per) >= THR;
    endfunction

    function automatic int exp_dir_idle(input logic [7:0] r);
        return (r[7:6] == 2'b11) ? 0 : int'(r[7:6]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_reg;
        bit exp_bad;
        int p;
        void'($urandom(32'h5EED));

        step(3);
        rst = 1'b0;
        step(1);
        exp_reg = {cfg_default[7:5], 5'b10000};
        check_eq("R1 reset register", rd_data, exp_reg);
        check_eq("R1 reset fault", sync_fault, 0);
        check_eq("R1 reset bad flag", bad_wr_flag, 0);
        check_eq("R11 disabled freq", freq_mode, 0);
        exp_bad = 0;

        // random register traffic
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom % 2 == 0) d[4:0] = 5'b10000;
            wr(d);
            if (d[4:0] == 5'b10000) exp_reg = d;
            else exp_bad = 1;
            check_eq("R2/R3 register value", rd_data, exp_reg);
            check_eq("R3 bad write flag", bad_wr_flag, exp_bad);
            check_eq("R4 idle direction", eff_dir, exp_dir_idle(exp_reg));
            if ($urandom % 4 == 0) begin
                pulse_clr();
                exp_bad = 0;
                check_eq("R3 flag clear", bad_wr_flag, 0);
            end
        end

        // drive mode, both edges
        for (int e = 0; e < 2; e++) begin
            wr({2'b01, e[0], 5'b10000});
            enable = 1'b1;
            #1;
            check_eq("R4 sync_oe in drive", sync_oe, 1);
            check_eq("R6 first driven level", sync_out, e);
            step(2);
            check_eq("R11 drive freq nominal", freq_mode, 1);
            meas_per(p);
            check_eq("R11 drive period", p, PER);
            enable = 1'b0;
            step(2);
            check_eq("R4 undriven when disabled", sync_oe, 0);
        end

        // follow mode enabled before edges, sticky fault, limit, park
        set_pin(0, 1'b0);
        wr(8'b10_1_10000);
        step(80);
        enable = 1'b1;
        step(5);
        check_eq("R7 fault without edges", sync_fault, 1);
        check_eq("R9 held code", freq_mode, 4);
        set_pin(PER, 1'b0);
        step(100);
        check_eq("R8 fault sticky", sync_fault, 1);
        pulse_clr();
        step(2);
        check_eq("R8 fault cleared", sync_fault, 0);
        check_eq("R9 tracking code", freq_mode, 2);
        set_pin(30, 1'b0);
        step(120);
        check_eq("R9 lower limit code", freq_mode, 3);
        wr(8'b01_1_10000);
        step(4);
        check_eq("R10 parked code", freq_mode, 5);
        meas_per(p);
        check_eq("R10 parked period", p, LIM);
        wr(8'b10_1_10000);
        step(3);
        check_eq("R10 park persists", freq_mode, 5);
        enable = 1'b0;
        step(2);
        check_eq("R11 off after disable", freq_mode, 0);
        check_eq("R8 fault cleared by disable", sync_fault, 0);
        wr(8'b01_1_10000);
        enable = 1'b1;
        step(3);
        check_eq("R10 nominal after re-enable", freq_mode, 1);
        meas_per(p);
        check_eq("R10 nominal period after re-enable", p, PER);
        enable = 1'b0;

        // loss of edges while running, then park from held
        wr(8'b10_0_10000);
        set_pin(PER, 1'b0);
        step(60);
        enable = 1'b1;
        step(100);
        check_eq("R7 no fault with edges", sync_fault, 0);
        check_eq("R9 tracking falling edges", freq_mode, 2);
        set_pin(0, 1'b0);
        step(80);
        check_eq("R7 fault on loss", sync_fault, 1);
        wr(8'b01_0_10000);
        step(3);
        check_eq("R10 park from held", freq_mode, 5);
        enable = 1'b0;
        step(2);

        // tracking switch to drive is not parked
        wr(8'b10_1_10000);
        set_pin(PER, 1'b0);
        step(60);
        enable = 1'b1;
        step(100);
        wr(8'b01_1_10000);
        step(3);
        check_eq("R10 normal switch code", freq_mode, 1);
        meas_per(p);
        check_eq("R10 normal switch period", p, PER);
        enable = 1'b0;
        step(2);

        // auto-detect trials
        for (int k = 0; k < 12; k++) begin
            int sel;
            int per;
            logic lvl;
            bit e;
            bit exp_in;
            int exp_d;
            sel = (k < 7) ? k : int'($urandom % 7);
            e = 1'($urandom);
            case (sel)
                0: begin per = 0;  lvl = 1'b0; end
                1: begin per = 0;  lvl = 1'b1; end
                2: begin per = 10; lvl = 1'b0; end
                3: begin per = 16; lvl = 1'b0; end
                4: begin per = 20; lvl = 1'b0; end
                5: begin per = 40; lvl = 1'b0; end
                default: begin per = 64; lvl = 1'b0; end
            endcase
            wr({2'b11, e, 5'b10000});
            set_pin(per, lvl);
            step(2 * WINC + 20);
            for (int w = 0; w < 100; w++) begin
                if (pin_half == 0 || exp_fast(per) ||
                    (tog_cnt >= 3 && tog_cnt <= pin_half - 4)) break;
                step(1);
            end
            exp_in = exp_fast(per) || sync_pin;
            exp_d = exp_in ? 2 : 1;
            enable = 1'b1;
            step(3);
            check_eq("R5 auto choice", eff_dir, exp_d);
            if (exp_in) set_pin(0, 1'b0);
            else set_pin(10, 1'b0);
            step(2 * WINC + 20);
            check_eq("R5 auto choice held", eff_dir, exp_d);
            enable = 1'b0;
            step(2);
            check_eq("R5 auto idle when disabled", eff_dir, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule